// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block is the digital control around a sigma-delta converter's calibration. Software writes a three-bit calibration command through a small register interface. The sequencer then runs an offset phase, a gain phase, or an offset phase followed by a gain phase. Each phase ends on the next conversion-cycle strobe. At the end of each phase, the measurement presented on `meas_data` is captured into the offset or the gain register. When the last phase finishes, the command bits fall back to zero and a done flag rises. Software clears the flag as a side effect of reading certain registers.

The same block corrects every raw conversion word before it reaches the data register. It subtracts the sign-magnitude offset and multiplies by the unsigned fixed-point gain. The result is clamped to the signed output range. Out of reset the offset is zero and the gain is unity, so conversions are usable before any calibration has been run. The analog front end uses `cal_phase` and `cal_system` to route its inputs during a calibration.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, these registers read as follows: gain 0x400000 (1.0, with the binary point at bit 22), offset 0, setup 0, data 0 and configuration 0. `done_flag` is 0, `cal_phase` is 0 and `cor_valid` is 0.
- R2: The command field is wr_data[2:0], with bit0 = offset step, bit1 = gain step and bit2 = system source. Codes 001, 010, 011, 101 and 110 are accepted when the sequencer is idle. In the cycle after the write, `cal_phase` shows the first phase (1 = offset, 2 = gain) and `cal_system` shows bit2.
- R3: Codes 000, 100 and 111 are ignored. The phase stays 0, the command bits read back as 000 and `done_flag` is unchanged.
- R4: A phase holds until the first `conv_strobe` sampled while it is active, so a single-step calibration takes exactly one strobe. On that strobe edge `meas_data` is loaded into the offset register (phase 1) or the gain register (phase 2).
- R5: Code 011 runs the offset phase and then the gain phase. This takes two strobes, and `done_flag` stays 0 after the first strobe.
- R6: On the edge that ends the last phase, `cal_phase` returns to 0, the command bits read back as 000 and `done_flag` becomes 1.
- R7: A read of data (1), offset (2), gain (3) or setup (4) clears `done_flag`. A read of configuration (0) or of selects 5–7 leaves it unchanged. When completion coincides with a clearing read, the flag is set. Accepting a new command clears the flag.
- R8: A configuration write while a phase is active is ignored entirely. The running sequence and its command bits carry on.
- R9: The register selects are 0 configuration, 1 data, 2 offset, 3 gain, 4 setup. The configuration read returns done in bit 3 and the command in bits 2:0. `rd_data` is valid the cycle after `rd_en`, and selects 5–7 read 0. Writes with select 2, 3 or 4 load that register, and writes to data are ignored.
- R10: The offset is sign-magnitude, with bit 23 = 1 meaning negative and bits 22:0 aligned to the same bit positions of the data word. The corrected word is floor((raw − signed offset) × gain / 2^22), clamped to [−2^23, 2^23−1]. It appears on `cor_data` with `cor_valid` one cycle after `raw_valid`.
- R11: The data register holds the most recent corrected word until the next `raw_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 24 | Write data; bits 2:0 carry the command on a configuration write |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 24 | Read data, registered |
| conv_strobe | input | 1 | One pulse per conversion cycle |
| meas_data | input | 24 | Calibration measurement captured at the end of a phase |
| raw_valid | input | 1 | Raw conversion word valid |
| raw_data | input | 24 | Raw two's-complement conversion word |
| cor_valid | output | 1 | Corrected word valid pulse |
| cor_data | output | 24 | Corrected word (data register) |
| cal_phase | output | 2 | 0 idle, 1 offset phase, 2 gain phase |
| cal_system | output | 1 | Active calibration uses the system input source |
| done_flag | output | 1 | Calibration complete flag |

## Verification
All eight command codes are driven from idle, with idle cycles before each strobe. A sequencer that ended a phase without a strobe, accepted an unused code or raised the done flag after the offset half of code 011 produces a phase or flag value that differs from the expected sequence. Every read select is issued with the flag set, so a design that cleared the flag on a configuration read, or kept it through a setup read, shows the wrong flag. Two collisions are also driven: a command write during an active phase, and a clearing read on the completion edge. The correction path is swept across positive and negative offsets, gains below and above unity, and input extremes. Any sign-handling, rounding or clamping error appears as a wrong corrected word.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_OFFSET = 2'd1,
        PH_GAIN   = 2'd2
    } cal_phase_e;

    typedef struct packed {
        logic sys;
        logic do_gain;
        logic do_off;
    } cal_cmd_t;

    typedef enum logic [2:0] {
        SEL_CFG    = 3'd0,
        SEL_DATA   = 3'd1,
        SEL_OFFSET = 3'd2,
        SEL_GAIN   = 3'd3,
        SEL_SETUP  = 3'd4
    } reg_sel_e;

    localparam int CMD_W    = 3;
    localparam int DONE_POS = 3;

    // A command is usable when it names at least one step; the
    // system-source combined form has no defined sequence.
    function automatic logic cmd_valid(cal_cmd_t c);
        return (c.do_off || c.do_gain) && !(c.sys && c.do_off && c.do_gain);
    endfunction

    function automatic cal_phase_e first_phase(cal_cmd_t c);
        return c.do_off ? PH_OFFSET : PH_GAIN;
    endfunction

    function automatic logic sel_clears_done(logic [2:0] s);
        return (s == SEL_DATA) || (s == SEL_OFFSET) ||
               (s == SEL_GAIN) || (s == SEL_SETUP);
    endfunction

endpackage

// File: rtl/cal_fsm.sv
module cal_fsm
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  cal_cmd_t   cfg_code,
    input  logic       conv_strobe,
    output cal_phase_e phase,
    output cal_cmd_t   cmd,
    output logic       start,
    output logic       cap_off,
    output logic       cap_gain,
    output logic       finish
);
    cal_phase_e phase_q;
    cal_cmd_t   cmd_q;

    always_comb begin
        start    = cfg_wr && (phase_q == PH_IDLE) && cmd_valid(cfg_code);
        cap_off  = conv_strobe && (phase_q == PH_OFFSET);
        cap_gain = conv_strobe && (phase_q == PH_GAIN);
        finish   = cap_gain || (cap_off && !cmd_q.do_gain);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
        end else if (start) begin
            phase_q <= first_phase(cfg_code);
            cmd_q   <= cfg_code;
        end else if (cap_off && cmd_q.do_gain) begin
            phase_q <= PH_GAIN;
        end else if (finish) begin
            phase_q <= PH_IDLE;
            cmd_q   <= '0;
        end
    end

    assign phase = phase_q;
    assign cmd   = cmd_q;
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
    parameter int DATA_W    = 24,
    parameter int GAIN_FRAC = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [DATA_W-1:0] offset,
    input  logic [DATA_W-1:0] gain,
    output logic              cor_valid,
    output logic [DATA_W-1:0] cor_data
);
    localparam int DIFF_W = DATA_W + 2;
    localparam int PROD_W = DIFF_W + DATA_W + 1;
    localparam int HEAD_W = PROD_W - DATA_W + 1;

    localparam logic signed [PROD_W-1:0] SAT_MAX = {{HEAD_W{1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SAT_MIN = {{HEAD_W{1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [DIFF_W-1:0] raw_ext, mag_ext, soff, diff;
    logic signed [PROD_W-1:0] diff_w, gain_w, prod, scaled;
    logic        [DATA_W-1:0] clamped;
    logic                     valid_q;
    logic        [DATA_W-1:0] data_q;

    always_comb begin
        raw_ext = {{2{raw_data[DATA_W-1]}}, raw_data};
        mag_ext = {3'b000, offset[DATA_W-2:0]};
        soff    = offset[DATA_W-1] ? -mag_ext : mag_ext;
        diff    = raw_ext - soff;
        diff_w  = {{(PROD_W-DIFF_W){diff[DIFF_W-1]}}, diff};
        gain_w  = {{(PROD_W-DATA_W){1'b0}}, gain};
        prod    = diff_w * gain_w;
        scaled  = prod >>> GAIN_FRAC;
        if (scaled > SAT_MAX)
            clamped = SAT_MAX[DATA_W-1:0];
        else if (scaled < SAT_MIN)
            clamped = SAT_MIN[DATA_W-1:0];
        else
            clamped = scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= raw_valid;
            if (raw_valid)
                data_q <= clamped;
        end
    end

    assign cor_valid = valid_q;
    assign cor_data  = data_q;
endmodule

// File: rtl/cal_regfile.sv
module cal_regfile
    import cal_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int GAIN_FRAC = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    input  logic [DATA_W-1:0] meas_data,
    input  logic              cap_off,
    input  logic              cap_gain,
    input  logic              start,
    input  logic              finish,
    input  cal_cmd_t          cmd,
    input  logic [DATA_W-1:0] data_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] gain,
    output logic              done
);
    localparam logic [DATA_W-1:0] GAIN_ONE =
        {{(DATA_W-1-GAIN_FRAC){1'b0}}, 1'b1, {GAIN_FRAC{1'b0}}};

    logic [DATA_W-1:0] off_q, gain_q, setup_q, rd_q, rd_next, cfg_word;
    logic              done_q;

    always_comb begin
        cfg_word           = '0;
        cfg_word[CMD_W-1:0] = cmd;
        cfg_word[DONE_POS] = done_q;
        case (rd_sel)
            SEL_CFG:    rd_next = cfg_word;
            SEL_DATA:   rd_next = data_word;
            SEL_OFFSET: rd_next = off_q;
            SEL_GAIN:   rd_next = gain_q;
            SEL_SETUP:  rd_next = setup_q;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q   <= '0;
            gain_q  <= GAIN_ONE;
            setup_q <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            // calibration capture takes precedence over a software write
            if (cap_off)
                off_q <= meas_data;
            else if (wr_en && wr_sel == SEL_OFFSET)
                off_q <= wr_data;

            if (cap_gain)
                gain_q <= meas_data;
            else if (wr_en && wr_sel == SEL_GAIN)
                gain_q <= wr_data;

            if (wr_en && wr_sel == SEL_SETUP)
                setup_q <= wr_data;

            if (rd_en)
                rd_q <= rd_next;

            if (finish)
                done_q <= 1'b1;
            else if (start)
                done_q <= 1'b0;
            else if (rd_en && sel_clears_done(rd_sel))
                done_q <= 1'b0;
        end
    end

    assign rd_data = rd_q;
    assign offset  = off_q;
    assign gain    = gain_q;
    assign done    = done_q;
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
    import cal_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int GAIN_FRAC = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              conv_strobe,
    input  logic [DATA_W-1:0] meas_data,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    output logic              cor_valid,
    output logic [DATA_W-1:0] cor_data,
    output logic [1:0]        cal_phase,
    output logic              cal_system,
    output logic              done_flag
);
    cal_phase_e        phase;
    cal_cmd_t          cmd_now;
    logic              cfg_wr, start, cap_off, cap_gain, finish;
    logic [DATA_W-1:0] offset, gain;

    assign cfg_wr = wr_en && (wr_sel == SEL_CFG);

    cal_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_code   (cal_cmd_t'(wr_data[CMD_W-1:0])),
        .conv_strobe(conv_strobe),
        .phase      (phase),
        .cmd        (cmd_now),
        .start      (start),
        .cap_off    (cap_off),
        .cap_gain   (cap_gain),
        .finish     (finish)
    );

    cal_regfile #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .meas_data(meas_data),
        .cap_off  (cap_off),
        .cap_gain (cap_gain),
        .start    (start),
        .finish   (finish),
        .cmd      (cmd_now),
        .data_word(cor_data),
        .rd_data  (rd_data),
        .offset   (offset),
        .gain     (gain),
        .done     (done_flag)
    );

    cal_corrector #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_cor (
        .clk      (clk),
        .rst      (rst),
        .raw_valid(raw_valid),
        .raw_data (raw_data),
        .offset   (offset),
        .gain     (gain),
        .cor_valid(cor_valid),
        .cor_data (cor_data)
    );

    assign cal_phase  = phase;
    assign cal_system = cmd_now.sys;
endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [2:0] wr_code,
    input logic       rd_en,
    input logic [2:0] rd_sel,
    input logic       conv_strobe,
    input logic [1:0] cal_phase,
    input logic [2:0] cmd_bits,
    input logic       done_flag,
    input logic       raw_valid,
    input logic       cor_valid
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cal_phase == PH_IDLE && !done_flag && cmd_bits == 3'b000));

    assert_unused_code_R3: assert property (@(posedge clk) disable iff (rst)
        (cal_phase == PH_IDLE && wr_en && wr_sel == SEL_CFG && !cmd_valid(cal_cmd_t'(wr_code)))
        |=> (cal_phase == PH_IDLE));

    assert_phase_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (cal_phase != PH_IDLE && conv_strobe) |=> (cal_phase != $past(cal_phase)));

    assert_phase_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (cal_phase != PH_IDLE && !conv_strobe) |=> $stable(cal_phase));

    assert_combined_order_R5: assert property (@(posedge clk) disable iff (rst)
        (cal_phase == PH_OFFSET && conv_strobe && cmd_bits == 3'b011)
        |=> (cal_phase == PH_GAIN && !done_flag));

    assert_done_on_finish_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (cal_phase == PH_IDLE && cmd_bits == 3'b000 && $past(cal_phase) != PH_IDLE));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_clears_done(rd_sel) && !conv_strobe) |=> !done_flag);

    assert_cfg_read_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_CFG && done_flag && !wr_en) |=> done_flag);

    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (cal_phase != PH_IDLE && wr_en && wr_sel == SEL_CFG && !conv_strobe) |=> $stable(cmd_bits));

    assert_cor_latency_R10: assert property (@(posedge clk) disable iff (rst)
        raw_valid |=> cor_valid);

    assert_cor_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> !cor_valid);
endmodule

bind cal_seq_top cal_seq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_code    (wr_data[2:0]),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .conv_strobe(conv_strobe),
    .cal_phase  (cal_phase),
    .cmd_bits   (cmd_now),
    .done_flag  (done_flag),
    .raw_valid  (raw_valid),
    .cor_valid  (cor_valid)
);

// File: tb/tb_cal_seq_top.sv
module tb_cal_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, conv_strobe = 1'b0, raw_valid = 1'b0;
    logic [2:0]  wr_sel = '0, rd_sel = '0;
    logic [23:0] wr_data = '0, meas_data = '0, raw_data = '0;
    logic [23:0] rd_data, cor_data;
    logic        cor_valid, cal_system, done_flag;
    logic [1:0]  cal_phase;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [23:0] m_off = 24'h0, m_gain = 24'h400000, m_setup = 24'h0, m_data = 24'h0;

    always #2.5 clk = ~clk;

    cal_seq_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .conv_strobe(conv_strobe),
        .meas_data(meas_data), .raw_valid(raw_valid), .raw_data(raw_data),
        .cor_valid(cor_valid), .cor_data(cor_data), .cal_phase(cal_phase),
        .cal_system(cal_system), .done_flag(done_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [23:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [23:0] v);
        @(negedge clk); rd_en = 1'b1; rd_sel = s;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    task automatic strobe(input logic [23:0] m);
        @(negedge clk); conv_strobe = 1'b1; meas_data = m;
        @(negedge clk); conv_strobe = 1'b0;
    endtask

    function automatic logic [23:0] exp_cor(input logic [23:0] raw, input logic [23:0] off,
                                            input logic [23:0] g);
        longint r, so, p, q;
        r  = longint'($signed(raw));
        so = longint'(off[22:0]);
        if (off[23]) so = -so;
        p = (r - so) * longint'(g);
        q = p >>> 22;
        if (q > 64'sd8388607)  q = 64'sd8388607;
        if (q < -64'sd8388608) q = -64'sd8388608;
        return q[23:0];
    endfunction

    // runs a code from idle and checks the whole sequence
    task automatic run_code(input logic [2:0] code, input logic [23:0] m1, input logic [23:0] m2);
        logic [23:0] v;
        bit ok;
        ok = (code == 3'b001) || (code == 3'b010) || (code == 3'b011) ||
             (code == 3'b101) || (code == 3'b110);
        wr(3'd0, {21'b0, code});
        if (!ok) begin
            chk("R3 phase after unused code", 32'(cal_phase), 32'd0);
            strobe(m1);
            chk("R3 phase after strobe", 32'(cal_phase), 32'd0);
            rd(3'd0, v);
            chk("R3 config after unused code", 32'(v), 32'h0);
        end else begin
            chk("R2 first phase", 32'(cal_phase), code[0] ? 32'd1 : 32'd2);
            chk("R2 system source", 32'(cal_system), 32'(code[2]));
            chk("R7 start clears done", 32'(done_flag), 32'd0);
            repeat (3) @(negedge clk);
            chk("R4 phase holds without strobe", 32'(cal_phase), code[0] ? 32'd1 : 32'd2);
            strobe(m1);
            if (code[0]) m_off = m1; else m_gain = m1;
            if (code == 3'b011) begin
                chk("R5 gain phase follows offset", 32'(cal_phase), 32'd2);
                chk("R5 done low after first strobe", 32'(done_flag), 32'd0);
                @(negedge clk);
                strobe(m2);
                m_gain = m2;
            end
            chk("R6 phase idle at end", 32'(cal_phase), 32'd0);
            chk("R6 done set at end", 32'(done_flag), 32'd1);
            rd(3'd0, v);
            chk("R6 config bits cleared, done bit3", 32'(v), 32'h8);
            chk("R7 config read keeps done", 32'(done_flag), 32'd1);
            rd(3'd2, v);
            chk("R4 offset register captured", 32'(v), 32'(m_off));
            rd(3'd3, v);
            chk("R4 gain register captured", 32'(v), 32'(m_gain));
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [23:0] offs [5] = '{24'h000000, 24'h000100, 24'h800100, 24'h7FFFFF, 24'h812345};
        logic [23:0] gains[4] = '{24'h400000, 24'h200000, 24'h600000, 24'hFFFFFF};
        logic [23:0] raws [7] = '{24'h000000, 24'h000001, 24'hFFFFFF, 24'h7FFFFF,
                                  24'h800000, 24'h123456, 24'hEDCBA9};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 phase", 32'(cal_phase), 32'd0);
        chk("R1 done", 32'(done_flag), 32'd0);
        chk("R1 cor_valid", 32'(cor_valid), 32'd0);
        rd(3'd3, v); chk("R1 gain unity", 32'(v), 32'h400000);
        rd(3'd2, v); chk("R1 offset zero", 32'(v), 32'h0);
        rd(3'd4, v); chk("R1 setup zero", 32'(v), 32'h0);
        rd(3'd1, v); chk("R1 data zero", 32'(v), 32'h0);
        rd(3'd0, v); chk("R1 config zero", 32'(v), 32'h0);

        // R2..R6: every command code from idle
        for (int c = 0; c < 8; c++) begin
            rd(3'd2, v);
            run_code(3'(c), 24'h010000 + 24'(c * 24'h1111), 24'h300000 + 24'(c));
        end

        // R9 register access
        wr(3'd4, 24'hABCDE5); m_setup = 24'hABCDE5;
        rd(3'd4, v); chk("R9 setup write/read", 32'(v), 32'(m_setup));
        wr(3'd1, 24'h555555);
        rd(3'd1, v); chk("R9 data not writable", 32'(v), 32'(m_data));

        // R7 clearing by select, R9 read contents
        for (int s = 0; s < 8; s++) begin
            wr(3'd0, 24'h1);
            strobe(24'h000020 + 24'(s)); m_off = 24'h000020 + 24'(s);
            chk("R6 done before select read", 32'(done_flag), 32'd1);
            rd(3'(s), v);
            case (s)
                0: chk("R9 config read value", 32'(v), 32'h8);
                1: chk("R9 data read value", 32'(v), 32'(m_data));
                2: chk("R9 offset read value", 32'(v), 32'(m_off));
                3: chk("R9 gain read value", 32'(v), 32'(m_gain));
                4: chk("R9 setup read value", 32'(v), 32'(m_setup));
                default: chk("R9 unmapped select reads 0", 32'(v), 32'h0);
            endcase
            chk("R7 done after select read", 32'(done_flag),
                (s >= 1 && s <= 4) ? 32'd0 : 32'd1);
        end

        // R7 completion wins over a clearing read in the same cycle
        wr(3'd0, 24'h1);
        @(negedge clk); conv_strobe = 1'b1; meas_data = 24'h000777; rd_en = 1'b1; rd_sel = 3'd2;
        @(negedge clk); conv_strobe = 1'b0; rd_en = 1'b0; m_off = 24'h000777;
        chk("R7 set wins over clearing read", 32'(done_flag), 32'd1);

        // R8 config write during an active phase
        wr(3'd0, 24'h2);
        wr(3'd0, 24'h1);
        chk("R8 phase unchanged by busy write", 32'(cal_phase), 32'd2);
        strobe(24'h500000); m_gain = 24'h500000;
        chk("R8 sequence finished after one strobe", 32'(cal_phase), 32'd0);
        chk("R8 done after original command", 32'(done_flag), 32'd1);
        rd(3'd2, v); chk("R8 offset untouched", 32'(v), 32'(m_off));
        rd(3'd3, v); chk("R8 gain captured", 32'(v), 32'(m_gain));

        // R10/R11 correction sweep
        foreach (offs[i]) begin
            foreach (gains[j]) begin
                wr(3'd2, offs[i]);
                wr(3'd3, gains[j]);
                foreach (raws[k]) begin
                    @(negedge clk); raw_valid = 1'b1; raw_data = raws[k];
                    @(negedge clk); raw_valid = 1'b0;
                    m_data = exp_cor(raws[k], offs[i], gains[j]);
                    chk("R10 cor_valid", 32'(cor_valid), 32'd1);
                    chk("R10 corrected word", 32'(cor_data), 32'(m_data));
                end
                @(negedge clk);
                chk("R11 data held", 32'(cor_data), 32'(m_data));
                rd(3'd1, v); chk("R11 data register read", 32'(v), 32'(m_data));
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule